// File: doc/BRIEF.md
# ATM Cell Header Check and Translation

This block sits at the ingress of a cell switch. It takes 53-octet ATM cells one octet per clock, holds each cell until it is complete, and checks the header error control octet. Cells that fail the check are discarded. For a good cell it searches a 16-entry routing table on the incoming path and channel identifiers. On a hit it replaces the identifiers, recomputes the header check octet and puts a 3-octet fabric routing header in front of the cell. That header carries the destination port bitmap, the priority and a multicast flag. The result is a 56-octet fabric frame sent on a valid/ready stream. A cell that matches no entry is dropped.

A one-bit mode input selects user-side or network-side header parsing. A write port loads, overwrites or deletes table entries. Two free-running counters report how many cells were dropped for a bad check octet and how many for a table miss.

Top module: `atm_cell_ingress`

## Requirements
- R1: An accepted octet with `inFirst` high becomes header octet 1 of a new cell and abandons any partial cell. Octets accepted without `inFirst` while no cell is open are ignored. A cell is complete after 53 octets.
- R2: Header octet 5 must equal a CRC-8 over octets 1 to 4. The CRC uses generator x^8+x^2+x+1 (0x07), starts from zero, runs MSB first and has no final XOR. On a mismatch the cell is discarded, no frame is sent and `hecDropCnt` increments by one.
- R3: With `nniMode`=0 the layout is: octet 1 bits 7:4 are a flow-control field, and the VPI is 8 bits taken from octet 1 bits 3:0 followed by octet 2 bits 7:4. With `nniMode`=1 the VPI is 12 bits taken from octet 1 followed by octet 2 bits 7:4. In both modes the VCI is octet 2 bits 3:0, then octet 3, then octet 4 bits 7:4.
- R4: A table entry matches when it is valid and its stored 12-bit VPI and 16-bit VCI equal the parsed key, where the 8-bit VPI is zero-extended. If several entries match, the lowest index wins.
- R5: A cell with a good check octet that matches no entry is discarded, no frame is sent and `missDropCnt` increments by one.
- R6: The outgoing header carries the entry's outgoing VPI and VCI in the same layout. In user-side mode the flow-control field is kept and the low 8 bits of the outgoing VPI are used. Octet 4 bits 3:0 (payload type and loss priority) pass through unchanged. Octet 5 is recomputed by the R2 rule over the new octets 1 to 4.
- R7: Frame octet 0 is bitmap bits 15:8 and octet 1 is bitmap bits 7:0, with the bitmap zero-extended to 16 bits. Octet 2 is {priority[1:0], multicast, 5'b0}, where multicast is 1 when more than one bitmap bit is set.
- R8: A frame is 56 octets: the 3 fabric octets, the 5 rewritten header octets, then the 48 payload octets in arrival order. `outLast` is high only on octet 56.
- R9: While `outValid` is high and `outReady` is low, `outData` and `outLast` hold. `inReady` is low from the cycle after a cell completes until its frame has been sent or the cell has been dropped.
- R10: When `tblWrEn` is high, the entry at `tblWrIdx` is written and becomes valid when `tblWrValid` is 1 or is deleted when it is 0. Reset deletes every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nniMode | input | 1 | 0 user-side header layout, 1 network-side layout |
| inValid | input | 1 | Input octet valid |
| inFirst | input | 1 | Marks header octet 1 of a cell |
| inData | input | 8 | Input octet |
| inReady | output | 1 | Block can accept an input octet |
| outValid | output | 1 | Output frame octet valid |
| outReady | input | 1 | Downstream accepts the output octet |
| outData | output | 8 | Output frame octet |
| outLast | output | 1 | Last octet of a frame |
| tblWrEn | input | 1 | Table write strobe |
| tblWrIdx | input | 4 | Entry index to write |
| tblWrValid | input | 1 | 1 installs the entry, 0 deletes it |
| tblWrInVpi | input | 12 | Incoming VPI to match |
| tblWrInVci | input | 16 | Incoming VCI to match |
| tblWrOutVpi | input | 12 | Replacement VPI |
| tblWrOutVci | input | 16 | Replacement VCI |
| tblWrPortMap | input | 16 | Destination port bitmap |
| tblWrPrio | input | 2 | Priority |
| hecDropCnt | output | 16 | Cells dropped for a bad check octet |
| missDropCnt | output | 16 | Cells dropped for a table miss |

## Verification
The bench sweeps every payload-type/loss-priority value in both modes and every flow-control value. A design that masked or shifted those bits, or forgot to recompute the check octet, would produce wrong header octets. It flips each bit of the check octet in turn; a design that checked only part of the octet would forward corrupted cells.

It installs two entries with the same key to catch a search that takes the highest index. It sends a user-side key whose network-side twin is in the table, which catches a design that ignores the upper VPI bits. It sends stray octets and a cell that restarts partway through to catch framing that counts from the wrong place. It also applies random backpressure, which exposes output data that moves while stalled or input that is accepted during transmission.

// File: rtl/atm_cell_ingress_pkg.sv
package atm_cell_ingress_pkg;
  localparam int CELL_OCTETS  = 53;
  localparam int HDR_OCTETS   = 5;
  localparam int FAB_OCTETS   = 3;
  localparam int FRAME_OCTETS = FAB_OCTETS + CELL_OCTETS;
  localparam int PRE_OCTETS   = FAB_OCTETS + HDR_OCTETS;
  localparam int PRE_W        = $clog2(PRE_OCTETS);
  localparam int POS_W        = $clog2(FRAME_OCTETS);
  localparam int VPI_W        = 12;
  localparam int VCI_W        = 16;
  localparam int MAP_W        = 16;

  typedef enum logic [1:0] {ST_FILL, ST_EVAL, ST_SEND} phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             bufWr;
    logic [POS_W-1:0] bufIdx;
    logic             hdrLatch;
    logic [POS_W-1:0] rdPos;
  } dpCtrl_t;

  // CRC-8, generator 0x07, zero start, MSB first, no final xor
  function automatic logic [7:0] hecOf(input logic [31:0] hdr);
    logic [7:0] crc;
    crc = 8'h00;
    for (int b = 3; b >= 0; b--) begin
      crc = crc ^ hdr[b*8 +: 8];
      for (int k = 0; k < 8; k++)
        crc = crc[7] ? ((crc << 1) ^ 8'h07) : (crc << 1);
    end
    return crc;
  endfunction
endpackage

// File: rtl/atm_route_table.sv
module atm_route_table
  import atm_cell_ingress_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 16,
  parameter int PRIO_W      = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wrEn,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wrIdx,
  input  logic                           wrValid,
  input  logic [VPI_W-1:0]               wrInVpi,
  input  logic [VCI_W-1:0]               wrInVci,
  input  logic [VPI_W-1:0]               wrOutVpi,
  input  logic [VCI_W-1:0]               wrOutVci,
  input  logic [NUM_PORTS-1:0]           wrPortMap,
  input  logic [PRIO_W-1:0]              wrPrio,
  input  logic [VPI_W-1:0]               keyVpi,
  input  logic [VCI_W-1:0]               keyVci,
  output logic                           hit,
  output logic [VPI_W-1:0]               hitOutVpi,
  output logic [VCI_W-1:0]               hitOutVci,
  output logic [NUM_PORTS-1:0]           hitPortMap,
  output logic [PRIO_W-1:0]              hitPrio
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0] entValid;
  logic [VPI_W-1:0]       entInVpi   [NUM_ENTRIES];
  logic [VCI_W-1:0]       entInVci   [NUM_ENTRIES];
  logic [VPI_W-1:0]       entOutVpi  [NUM_ENTRIES];
  logic [VCI_W-1:0]       entOutVci  [NUM_ENTRIES];
  logic [NUM_PORTS-1:0]   entPortMap [NUM_ENTRIES];
  logic [PRIO_W-1:0]      entPrio    [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]       selIdx;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    logic wrHere;
    assign wrHere = wrEn && (wrIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      entValid[e] <= 1'b0;
      else if (wrHere) entValid[e] <= wrValid;
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        entInVpi[e]   <= wrInVpi;
        entInVci[e]   <= wrInVci;
        entOutVpi[e]  <= wrOutVpi;
        entOutVci[e]  <= wrOutVci;
        entPortMap[e] <= wrPortMap;
        entPrio[e]    <= wrPrio;
      end
    end

    assign matchVec[e] = entValid[e] && (entInVpi[e] == keyVpi) && (entInVci[e] == keyVci);
  end

  // lowest matching index wins
  always_comb begin
    selIdx = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--)
      if (matchVec[e]) selIdx = IDX_W'(e);
  end

  assign hit        = |matchVec;
  assign hitOutVpi  = entOutVpi[selIdx];
  assign hitOutVci  = entOutVci[selIdx];
  assign hitPortMap = entPortMap[selIdx];
  assign hitPrio    = entPrio[selIdx];
endmodule

// File: rtl/atm_ingress_dp.sv
module atm_ingress_dp
  import atm_cell_ingress_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int PRIO_W    = 2
) (
  input  logic                 clk,
  input  logic                 nniMode,
  input  dpCtrl_t              ctl,
  input  logic [7:0]           inData,
  input  logic [VPI_W-1:0]     tblOutVpi,
  input  logic [VCI_W-1:0]     tblOutVci,
  input  logic [NUM_PORTS-1:0] tblPortMap,
  input  logic [PRIO_W-1:0]    tblPrio,
  output logic [VPI_W-1:0]     keyVpi,
  output logic [VCI_W-1:0]     keyVci,
  output logic                 hecOk,
  output logic [7:0]           outData
);
  logic [7:0] cellBuf  [CELL_OCTETS];
  logic [7:0] frameHdr [PRE_OCTETS];
  logic [7:0] newHdr   [PRE_OCTETS];
  logic [MAP_W-1:0] mapWide;
  logic       mcast;

  always_ff @(posedge clk) begin
    if (ctl.bufWr) cellBuf[ctl.bufIdx] <= inData;
  end

  // header parse
  assign keyVpi = nniMode ? {cellBuf[0], cellBuf[1][7:4]}
                          : {4'h0, cellBuf[0][3:0], cellBuf[1][7:4]};
  assign keyVci = {cellBuf[1][3:0], cellBuf[2], cellBuf[3][7:4]};
  assign hecOk  = (cellBuf[4] == hecOf({cellBuf[0], cellBuf[1], cellBuf[2], cellBuf[3]}));

  // fabric header and rewritten cell header
  assign mapWide = MAP_W'(tblPortMap);
  assign mcast   = ($countones(tblPortMap) > 1);

  always_comb begin
    newHdr[0] = mapWide[15:8];
    newHdr[1] = mapWide[7:0];
    newHdr[2] = '0;
    newHdr[2][7 -: PRIO_W] = tblPrio;
    newHdr[2][7 - PRIO_W]  = mcast;
    newHdr[3] = nniMode ? tblOutVpi[11:4] : {cellBuf[0][7:4], tblOutVpi[7:4]};
    newHdr[4] = {tblOutVpi[3:0], tblOutVci[15:12]};
    newHdr[5] = tblOutVci[11:4];
    newHdr[6] = {tblOutVci[3:0], cellBuf[3][3:0]};
    newHdr[7] = hecOf({newHdr[3], newHdr[4], newHdr[5], newHdr[6]});
  end

  always_ff @(posedge clk) begin
    if (ctl.hdrLatch)
      for (int i = 0; i < PRE_OCTETS; i++) frameHdr[i] <= newHdr[i];
  end

  // output octet select: prefix from latch, payload straight from the cell store
  always_comb begin
    if (ctl.rdPos < POS_W'(PRE_OCTETS)) outData = frameHdr[ctl.rdPos[PRE_W-1:0]];
    else                                outData = cellBuf[ctl.rdPos - POS_W'(FAB_OCTETS)];
  end
endmodule

// File: rtl/atm_ingress_ctrl.sv
module atm_ingress_ctrl
  import atm_cell_ingress_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             inFirst,
  output logic             inReady,
  input  logic             outReady,
  output logic             outValid,
  output logic             outLast,
  input  logic             hecOk,
  input  logic             tblHit,
  output dpCtrl_t          ctl,
  output logic [CNT_W-1:0] hecDropCnt,
  output logic [CNT_W-1:0] missDropCnt
);
  localparam logic [POS_W-1:0] LAST_IN  = POS_W'(CELL_OCTETS - 1);
  localparam logic [POS_W-1:0] LAST_OUT = POS_W'(FRAME_OCTETS - 1);

  phase_t           phase;
  logic [POS_W-1:0] fillPos;
  logic [POS_W-1:0] sendPos;
  logic             accept;

  assign inReady  = (phase == ST_FILL);
  assign accept   = inValid && inReady;
  assign outValid = (phase == ST_SEND);
  assign outLast  = outValid && (sendPos == LAST_OUT);

  always_comb begin
    ctl.bufWr    = accept && (inFirst || (fillPos != '0));
    ctl.bufIdx   = inFirst ? '0 : fillPos;
    ctl.hdrLatch = (phase == ST_EVAL) && hecOk && tblHit;
    ctl.rdPos    = sendPos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= ST_FILL;
      fillPos     <= '0;
      sendPos     <= '0;
      hecDropCnt  <= '0;
      missDropCnt <= '0;
    end else begin
      case (phase)
        ST_FILL: begin
          if (accept) begin
            if (inFirst) fillPos <= POS_W'(1);
            else if (fillPos != '0) begin
              if (fillPos == LAST_IN) begin
                fillPos <= '0;
                phase   <= ST_EVAL;
              end else begin
                fillPos <= fillPos + 1'b1;
              end
            end
          end
        end
        ST_EVAL: begin
          if (!hecOk) begin
            hecDropCnt <= hecDropCnt + 1'b1;
            phase      <= ST_FILL;
          end else if (!tblHit) begin
            missDropCnt <= missDropCnt + 1'b1;
            phase       <= ST_FILL;
          end else begin
            sendPos <= '0;
            phase   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (outReady) begin
            if (sendPos == LAST_OUT) begin
              sendPos <= '0;
              phase   <= ST_FILL;
            end else begin
              sendPos <= sendPos + 1'b1;
            end
          end
        end
        default: phase <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/atm_cell_ingress.sv
module atm_cell_ingress
  import atm_cell_ingress_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 16,
  parameter int PRIO_W      = 2,
  parameter int CNT_W       = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           nniMode,
  input  logic                           inValid,
  input  logic                           inFirst,
  input  logic [7:0]                     inData,
  output logic                           inReady,
  output logic                           outValid,
  input  logic                           outReady,
  output logic [7:0]                     outData,
  output logic                           outLast,
  input  logic                           tblWrEn,
  input  logic [$clog2(NUM_ENTRIES)-1:0] tblWrIdx,
  input  logic                           tblWrValid,
  input  logic [11:0]                    tblWrInVpi,
  input  logic [15:0]                    tblWrInVci,
  input  logic [11:0]                    tblWrOutVpi,
  input  logic [15:0]                    tblWrOutVci,
  input  logic [NUM_PORTS-1:0]           tblWrPortMap,
  input  logic [PRIO_W-1:0]              tblWrPrio,
  output logic [CNT_W-1:0]               hecDropCnt,
  output logic [CNT_W-1:0]               missDropCnt
);
  dpCtrl_t              ctl;
  logic                 hecOk;
  logic                 tblHit;
  logic [VPI_W-1:0]     keyVpi;
  logic [VCI_W-1:0]     keyVci;
  logic [VPI_W-1:0]     tblOutVpi;
  logic [VCI_W-1:0]     tblOutVci;
  logic [NUM_PORTS-1:0] tblPortMap;
  logic [PRIO_W-1:0]    tblPrio;

  atm_ingress_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .inValid(inValid), .inFirst(inFirst), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .outLast(outLast),
    .hecOk(hecOk), .tblHit(tblHit), .ctl(ctl),
    .hecDropCnt(hecDropCnt), .missDropCnt(missDropCnt)
  );

  atm_ingress_dp #(.NUM_PORTS(NUM_PORTS), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .nniMode(nniMode), .ctl(ctl), .inData(inData),
    .tblOutVpi(tblOutVpi), .tblOutVci(tblOutVci),
    .tblPortMap(tblPortMap), .tblPrio(tblPrio),
    .keyVpi(keyVpi), .keyVci(keyVci), .hecOk(hecOk), .outData(outData)
  );

  atm_route_table #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .PRIO_W(PRIO_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wrEn(tblWrEn), .wrIdx(tblWrIdx), .wrValid(tblWrValid),
    .wrInVpi(tblWrInVpi), .wrInVci(tblWrInVci),
    .wrOutVpi(tblWrOutVpi), .wrOutVci(tblWrOutVci),
    .wrPortMap(tblWrPortMap), .wrPrio(tblWrPrio),
    .keyVpi(keyVpi), .keyVci(keyVci),
    .hit(tblHit), .hitOutVpi(tblOutVpi), .hitOutVci(tblOutVci),
    .hitPortMap(tblPortMap), .hitPrio(tblPrio)
  );
endmodule

// File: rtl/atm_cell_ingress_chk.sv
module atm_cell_ingress_chk
  import atm_cell_ingress_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outData,
  input logic             outLast,
  input logic [CNT_W-1:0] hecDropCnt,
  input logic [CNT_W-1:0] missDropCnt
);
  logic [POS_W-1:0] beatCnt;
  logic [15:0]      mapSeen;

  // beat position and bitmap seen at the ports
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beatCnt <= '0;
      mapSeen <= '0;
    end else if (outValid && outReady) begin
      if (beatCnt == POS_W'(0)) mapSeen[15:8] <= outData;
      if (beatCnt == POS_W'(1)) mapSeen[7:0]  <= outData;
      beatCnt <= outLast ? '0 : beatCnt + 1'b1;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  assert_in_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady);

  assert_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outLast == (beatCnt == POS_W'(FRAME_OCTETS - 1))));

  assert_mcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && (beatCnt == POS_W'(2)) |->
      (outData[5] == ($countones(mapSeen) > 1)) && (outData[4:0] == 5'd0));

  assert_hec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hecDropCnt != $past(hecDropCnt)) |->
      (hecDropCnt == CNT_W'($past(hecDropCnt) + 1'b1)) && !outValid);

  assert_miss_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (missDropCnt != $past(missDropCnt)) |->
      (missDropCnt == CNT_W'($past(missDropCnt) + 1'b1)) && !outValid);
endmodule

bind atm_cell_ingress atm_cell_ingress_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
  .hecDropCnt(hecDropCnt), .missDropCnt(missDropCnt)
);

// File: tb/atm_cell_ingress_tb.sv
`timescale 1ns/1ps
module atm_cell_ingress_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nniMode = 1'b0;
  logic        inValid = 1'b0, inFirst = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady;
  logic        outValid, outLast;
  logic        outReady = 1'b0;
  logic [7:0]  outData;
  logic        tblWrEn = 1'b0, tblWrValid = 1'b0;
  logic [3:0]  tblWrIdx = 4'h0;
  logic [11:0] tblWrInVpi = '0, tblWrOutVpi = '0;
  logic [15:0] tblWrInVci = '0, tblWrOutVci = '0;
  logic [15:0] tblWrPortMap = '0;
  logic [1:0]  tblWrPrio = '0;
  logic [15:0] hecDropCnt, missDropCnt;

  always #2.5 clk = ~clk;

  atm_cell_ingress u_dut (
    .clk(clk), .rst_n(rst_n), .nniMode(nniMode),
    .inValid(inValid), .inFirst(inFirst), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrValid(tblWrValid),
    .tblWrInVpi(tblWrInVpi), .tblWrInVci(tblWrInVci),
    .tblWrOutVpi(tblWrOutVpi), .tblWrOutVci(tblWrOutVci),
    .tblWrPortMap(tblWrPortMap), .tblWrPrio(tblWrPrio),
    .hecDropCnt(hecDropCnt), .missDropCnt(missDropCnt)
  );

  int nChk = 0, nFail = 0;
  int eHec = 0, eMiss = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench mirror of the routing table
  logic        mValid  [16];
  logic [11:0] mInVpi  [16];
  logic [15:0] mInVci  [16];
  logic [11:0] mOutVpi [16];
  logic [15:0] mOutVci [16];
  logic [15:0] mMap    [16];
  logic [1:0]  mPrio   [16];

  logic [7:0] cellOct  [53];
  logic [7:0] expFrame [56];

  function automatic logic [7:0] crc8(input logic [7:0] a, b, c, d);
    logic [7:0] r;
    logic [31:0] w;
    r = 8'h00;
    w = {a, b, c, d};
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = r[7] ^ w[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic tblWrite(input int idx, input bit v, input logic [11:0] iVpi, input logic [15:0] iVci,
                          input logic [11:0] oVpi, input logic [15:0] oVci,
                          input logic [15:0] map, input logic [1:0] pr);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = 4'(idx); tblWrValid = v;
    tblWrInVpi = iVpi; tblWrInVci = iVci; tblWrOutVpi = oVpi; tblWrOutVci = oVci;
    tblWrPortMap = map; tblWrPrio = pr;
    @(posedge clk); #1;
    tblWrEn = 1'b0;
    mValid[idx] = v; mInVpi[idx] = iVpi; mInVci[idx] = iVci;
    mOutVpi[idx] = oVpi; mOutVci[idx] = oVci; mMap[idx] = map; mPrio[idx] = pr;
  endtask

  task automatic pushOctet(input logic [7:0] d, input bit first);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = d; inFirst = first;
    @(posedge clk); #1;
    inValid = 1'b0; inFirst = 1'b0;
  endtask

  task automatic buildCell(input bit nni, input logic [3:0] gfc, input logic [11:0] vpi,
                           input logic [15:0] vci, input logic [3:0] ptc,
                           input logic [7:0] hecFlip, input logic [7:0] seed);
    cellOct[0] = nni ? vpi[11:4] : {gfc, vpi[7:4]};
    cellOct[1] = {vpi[3:0], vci[15:12]};
    cellOct[2] = vci[11:4];
    cellOct[3] = {vci[3:0], ptc};
    cellOct[4] = crc8(cellOct[0], cellOct[1], cellOct[2], cellOct[3]) ^ hecFlip;
    for (int i = 0; i < 48; i++) cellOct[5+i] = seed + 8'(i * 7);
  endtask

  task automatic sendCell();
    pushOctet(cellOct[0], 1'b1);
    for (int i = 1; i < 53; i++) pushOctet(cellOct[i], 1'b0);
  endtask

  // model: returns kind 0 frame, 1 check-octet drop, 2 miss drop
  task automatic modelCell(input bit nni, output int kind);
    logic [11:0] kv;
    logic [15:0] kc;
    int sel;
    kv = nni ? {cellOct[0], cellOct[1][7:4]} : {4'h0, cellOct[0][3:0], cellOct[1][7:4]};
    kc = {cellOct[1][3:0], cellOct[2], cellOct[3][7:4]};
    sel = -1;
    for (int e = 15; e >= 0; e--)
      if (mValid[e] && mInVpi[e] == kv && mInVci[e] == kc) sel = e;
    if (cellOct[4] != crc8(cellOct[0], cellOct[1], cellOct[2], cellOct[3])) kind = 1;
    else if (sel < 0) kind = 2;
    else begin
      kind = 0;
      expFrame[0] = mMap[sel][15:8];
      expFrame[1] = mMap[sel][7:0];
      expFrame[2] = {mPrio[sel], ($countones(mMap[sel]) > 1) ? 1'b1 : 1'b0, 5'b0};
      expFrame[3] = nni ? mOutVpi[sel][11:4] : {cellOct[0][7:4], mOutVpi[sel][7:4]};
      expFrame[4] = {mOutVpi[sel][3:0], mOutVci[sel][15:12]};
      expFrame[5] = mOutVci[sel][11:4];
      expFrame[6] = {mOutVci[sel][3:0], cellOct[3][3:0]};
      expFrame[7] = crc8(expFrame[3], expFrame[4], expFrame[5], expFrame[6]);
      for (int i = 5; i < 53; i++) expFrame[i+3] = cellOct[i];
    end
  endtask

  task automatic expectFrame(input string tag, input bit bp);
    int beat, guard;
    bit stall;
    logic [7:0] stallData;
    logic rdy;
    beat = 0; guard = 0; stall = 1'b0; stallData = 8'h00;
    while (beat < 56 && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (stall) chk(outValid && outData == stallData, {tag, " R9 hold"}, int'(outData), int'(stallData));
      if (outValid) chk(!inReady, {tag, " R9 inReady"}, int'(inReady), 0);
      rdy = bp ? lfsr[0] : 1'b1;
      stepLfsr();
      outReady = rdy;
      if (outValid && rdy) begin
        chk(outData == expFrame[beat],
            $sformatf("%s %s octet %0d", tag, (beat < 3) ? "R7" : (beat < 8) ? "R6" : "R8", beat),
            int'(outData), int'(expFrame[beat]));
        chk(outLast == (beat == 55), {tag, " R8 last"}, int'(outLast), int'(beat == 55));
        beat++;
        stall = 1'b0;
      end else begin
        stall = outValid;
        stallData = outData;
      end
    end
    @(negedge clk);
    outReady = 1'b0;
    if (beat < 56) chk(1'b0, {tag, " R8 frame incomplete"}, beat, 56);
  endtask

  task automatic expectDrop(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!outValid, {tag, " no frame"}, int'(outValid), 0);
    end
    chk(hecDropCnt == 16'(eHec), {tag, " R2 count"}, int'(hecDropCnt), eHec);
    chk(missDropCnt == 16'(eMiss), {tag, " R5 count"}, int'(missDropCnt), eMiss);
  endtask

  task automatic runCell(input string tag, input bit nni, input logic [3:0] gfc,
                         input logic [11:0] vpi, input logic [15:0] vci, input logic [3:0] ptc,
                         input logic [7:0] hecFlip, input bit bp);
    int kind;
    @(negedge clk);
    nniMode = nni;
    buildCell(nni, gfc, vpi, vci, ptc, hecFlip, 8'(vci[7:0] + 8'(ptc)));
    modelCell(nni, kind);
    sendCell();
    if (kind == 0) expectFrame(tag, bp);
    else begin
      if (kind == 1) eHec++; else eMiss++;
      expectDrop(tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    for (int e = 0; e < 16; e++) begin
      mValid[e] = 1'b0; mInVpi[e] = '0; mInVci[e] = '0;
      mOutVpi[e] = '0; mOutVci[e] = '0; mMap[e] = '0; mPrio[e] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "reset R9 inReady", int'(inReady), 1);
    chk(outValid == 1'b0, "reset R8 outValid", int'(outValid), 0);
    chk(hecDropCnt == 16'd0, "reset R2 counter", int'(hecDropCnt), 0);
    chk(missDropCnt == 16'd0, "reset R5 counter", int'(missDropCnt), 0);

    // R10: empty table after reset, every cell misses
    runCell("R10 empty table", 1'b0, 4'h0, 12'h000, 16'h0020, 4'h0, 8'h00, 1'b0);

    tblWrite(0,  1'b1, 12'h005, 16'h0100, 12'h0A3, 16'h1234, 16'h0004, 2'd1);
    tblWrite(1,  1'b1, 12'h005, 16'h0100, 12'h55A, 16'hCAFE, 16'h0010, 2'd3);
    tblWrite(2,  1'b1, 12'h7C1, 16'hBEEF, 12'h9F2, 16'h0042, 16'h8101, 2'd2);
    tblWrite(3,  1'b1, 12'h0FF, 16'hFFFF, 12'h3C5, 16'h8001, 16'hFFFF, 2'd0);
    tblWrite(15, 1'b1, 12'h000, 16'h0020, 12'hABC, 16'h7777, 16'h0001, 2'd3);

    // R4: duplicate key, lowest entry wins; R6 user-side rewrite
    runCell("R4 dup key", 1'b0, 4'hA, 12'h005, 16'h0100, 4'h5, 8'h00, 1'b0);
    // R3: network-side 12-bit VPI, multicast bitmap
    runCell("R3 nni mcast", 1'b1, 4'h0, 12'h7C1, 16'hBEEF, 4'hE, 8'h00, 1'b1);
    // R4: user-side key cannot reach an entry whose upper VPI bits are set
    runCell("R4 uni upper bits", 1'b0, 4'h7, 12'h0C1, 16'hBEEF, 4'h1, 8'h00, 1'b0);
    // R5: unknown key in network mode
    runCell("R5 miss", 1'b1, 4'h0, 12'hFFF, 16'h0001, 4'h0, 8'h00, 1'b0);
    // R3: same table entry reached in both modes
    runCell("R3 uni bcast", 1'b0, 4'h3, 12'h0FF, 16'hFFFF, 4'hF, 8'h00, 1'b1);
    runCell("R3 nni bcast", 1'b1, 4'h0, 12'h0FF, 16'hFFFF, 4'h0, 8'h00, 1'b1);

    // R2: each single-bit error in the check octet
    for (int b = 0; b < 8; b++)
      runCell("R2 bad check octet", b[0], 4'h2, 12'h005, 16'h0100, 4'h3, 8'(1 << b), 1'b0);

    // R1: stray octets before any start are ignored
    @(negedge clk); nniMode = 1'b0;
    for (int i = 0; i < 5; i++) pushOctet(8'hE0 + 8'(i), 1'b0);
    runCell("R1 stray octets", 1'b0, 4'h9, 12'h000, 16'h0020, 4'h6, 8'h00, 1'b0);

    // R1: a start mid-cell abandons the partial cell
    buildCell(1'b0, 4'h1, 12'h0FF, 16'hFFFF, 4'h2, 8'h00, 8'h11);
    pushOctet(cellOct[0], 1'b1);
    for (int i = 1; i < 20; i++) pushOctet(cellOct[i], 1'b0);
    runCell("R1 restart", 1'b0, 4'h4, 12'h005, 16'h0100, 4'h8, 8'h00, 1'b1);

    // R10: deleting entry 0 exposes entry 1 for the same key
    tblWrite(0, 1'b0, 12'h005, 16'h0100, 12'h000, 16'h0000, 16'h0000, 2'd0);
    runCell("R10 delete", 1'b0, 4'hB, 12'h005, 16'h0100, 4'hC, 8'h00, 1'b0);
    // R10: overwrite entry 2 with a user-reachable key
    tblWrite(2, 1'b1, 12'h0C1, 16'hBEEF, 12'h0E7, 16'h5A5A, 16'h0300, 2'd2);
    runCell("R10 overwrite", 1'b0, 4'h7, 12'h0C1, 16'hBEEF, 4'h1, 8'h00, 1'b1);

    // R6: sweep payload-type/loss-priority bits in both modes
    for (int p = 0; p < 16; p++) begin
      runCell("R6 ptc sweep uni", 1'b0, 4'h5, 12'h000, 16'h0020, 4'(p), 8'h00, p[0]);
      runCell("R6 ptc sweep nni", 1'b1, 4'h0, 12'h000, 16'h0020, 4'(p), 8'h00, p[1]);
    end
    // R6: sweep flow-control field
    for (int g = 0; g < 16; g++)
      runCell("R6 gfc sweep", 1'b0, 4'(g), 12'h0FF, 16'hFFFF, 4'h9, 8'h00, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule